// File: doc/BRIEF.md
# DMA Channel Status and Condition Register Block

This block is the software-facing register file of a single DMA channel. A 32-bit memory-mapped bus reaches a 16-bit channel status word. The upper byte of that word holds the run-state flags. The lower byte holds eight device-defined status bits. Each write to the control offset carries its own per-bit enable mask in the upper half-word, so software can change any subset of status bits in one access without a read-modify-write.

Three condition selectors, for interrupt, branch and wait, each compare the device-defined byte against a stored mask and value. Each drives a registered condition output that is high while `(dev & mask) == value`. The engine side can overwrite device-defined bits through its own masked port. The block also keeps the command-pointer pair and forces the low pointer onto 16-byte descriptor boundaries. Descriptor fetch and data movement live in the engine that consumes these outputs.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset, the status word, all three selectors and both command-pointer registers read zero, and every flag and condition output is low.
- R2: A write to offset 0x00 changes only those status bits whose enable bit in wdata[31:16] is set, loading them from wdata[15:0]. A read of offset 0x04 returns the 16-bit status zero-extended to 32 bits.
- R3: Run-state flags sit at fixed status positions: run bit 15, pause bit 14, wake bit 12, dead bit 11. The outputs `run_o`, `pause_o`, `wake_o` and `dead_o` follow them in the cycle after the write.
- R4: Status bit 10 (active) is read-only. It becomes 1 one cycle after run=1 with pause=0 and dead=0 holds, and it drops one cycle after run, pause or dead leaves that state.
- R5: When no control write targets a device-defined bit, an engine-side update writes `hw_dev_val` into the bits selected by `hw_dev_mask`. Engine updates never touch bits 15:8.
- R6: If a control write and an engine update target the same device-defined bit in one cycle, the control write's value wins. Engine-selected bits that the write does not enable still take the engine value.
- R7: Selectors sit at 0x10 (interrupt), 0x14 (branch) and 0x18 (wait). Each stores a mask from wdata[23:16] and a value from wdata[7:0]. It reads back in the same positions, with all other bits zero.
- R8: Each condition output equals `(dev_status & mask) == value`, registered, so it reflects a change of status or selector one cycle after that change is visible.
- R9: A write to 0x0C stores the command pointer with bits 3:0 forced to zero. The stored value is readable at 0x0C and drives `cmd_ptr`.
- R10: A write to 0x08 stores all 32 bits of the high command pointer, readable at 0x08 and on `cmd_ptr_hi`.
- R11: Read data is valid with `bus_rvalid` one cycle after `bus_re`. Offset 0x00 and unmapped offsets read zero, and writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| hw_dev_mask | input | 8 | Engine-side select of device bits to update |
| hw_dev_val | input | 8 | Engine-side values for selected device bits |
| dev_status | output | 8 | Device-defined status byte |
| run_o | output | 1 | Run flag |
| pause_o | output | 1 | Pause flag |
| wake_o | output | 1 | Wake flag |
| dead_o | output | 1 | Dead flag |
| active_o | output | 1 | Channel active |
| irq_cond | output | 1 | Interrupt selector condition |
| branch_cond | output | 1 | Branch selector condition |
| wait_cond | output | 1 | Wait selector condition |
| cmd_ptr | output | 32 | Aligned command pointer |
| cmd_ptr_hi | output | 32 | High command pointer |

## Verification
The bench issues the run, pause, wake and stop control words and samples `active_o` both in the cycle the flags change and one cycle later. A design without the one-cycle lag, or one that let software write bit 10, shows up on that second sample. It collides a control write with an engine update on overlapping and disjoint device bits, which catches a design that gives the engine priority or lets the write discard engine bits it does not enable. Conditions are sampled before and after their register stage with mask-zero, partial-mask and changing-status cases, which catches an inverted compare or a mask applied to the value. Pointer alignment, selector readback zeros and unmapped-offset writes are read back over the bus.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  // Run-state flag positions inside the 16-bit status word.
  localparam int BIT_RUN    = 15;
  localparam int BIT_PAUSE  = 14;
  localparam int BIT_WAKE   = 12;
  localparam int BIT_DEAD   = 11;
  localparam int BIT_ACTIVE = 10;

  // Word indices (byte offset / 4) of the register map.
  localparam int WIDX_CTRL   = 0;
  localparam int WIDX_STAT   = 1;
  localparam int WIDX_PTR_HI = 2;
  localparam int WIDX_PTR    = 3;
  localparam int WIDX_SEL0   = 4;  // interrupt, branch, wait follow in order

  localparam int NUM_SEL  = 3;
  localparam int SEL_IRQ  = 0;
  localparam int SEL_BR   = 1;
  localparam int SEL_WAIT = 2;
endpackage

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_chan_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int DEV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [STAT_W-1:0] ctl_en,
  input  logic [STAT_W-1:0] ctl_val,
  input  logic [DEV_W-1:0]  hw_mask,
  input  logic [DEV_W-1:0]  hw_val,
  output logic [STAT_W-1:0] stat_o,
  output logic              active_o
);
  localparam logic [STAT_W-1:0] RO_BITS = STAT_W'(1) << BIT_ACTIVE;

  logic [STAT_W-1:0] flags_q, flags_d, hw_merged, en_eff;
  logic              active_q;

  always_comb begin
    hw_merged              = flags_q;
    hw_merged[DEV_W-1:0]   = (flags_q[DEV_W-1:0] & ~hw_mask) | (hw_val & hw_mask);
    en_eff                 = ctl_we ? (ctl_en & ~RO_BITS) : '0;
    flags_d                = (hw_merged & ~en_eff) | (ctl_val & en_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      active_q <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      active_q <= flags_q[BIT_RUN] & ~flags_q[BIT_PAUSE] & ~flags_q[BIT_DEAD];
    end
  end

  always_comb begin
    stat_o             = flags_q;
    stat_o[BIT_ACTIVE] = active_q;
  end
  assign active_o = active_q;

  assert_run_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(ctl_we && ctl_en[BIT_RUN]) |=> $stable(flags_q[BIT_RUN]));
  assert_active_drop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q[BIT_RUN]) |=> !active_q);
  assert_active_src_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> $past(flags_q[BIT_RUN]));
  assert_engine_no_runstate_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(flags_q[STAT_W-1:DEV_W]));
  assert_sw_wins_R6: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ((flags_q[DEV_W-1:0] & $past(ctl_en[DEV_W-1:0])) ==
                ($past(ctl_val[DEV_W-1:0]) & $past(ctl_en[DEV_W-1:0]))));
endmodule

// File: rtl/dma_cond_sel.sv
module dma_cond_sel #(
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DEV_W-1:0] wr_mask,
  input  logic [DEV_W-1:0] wr_value,
  input  logic [DEV_W-1:0] dev_status,
  output logic [DEV_W-1:0] mask_o,
  output logic [DEV_W-1:0] value_o,
  output logic             cond_o
);
  logic [DEV_W-1:0] mask_q, value_q;
  logic             cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      value_q <= '0;
      cond_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        mask_q  <= wr_mask;
        value_q <= wr_value;
      end
      cond_q <= ((dev_status & mask_q) == value_q);
    end
  end

  assign mask_o  = mask_q;
  assign value_o = value_q;
  assign cond_o  = cond_q;

  assert_sel_store_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mask_q == $past(wr_mask) && value_q == $past(wr_value)));
  assert_cond_open_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0 && value_q == '0) |=> cond_q);
  assert_cond_unreachable_R8: assert property (@(posedge clk) disable iff (rst)
    ((value_q & ~mask_q) != '0) |=> !cond_q);
endmodule

// File: rtl/dma_cmd_ptr.sv
module dma_cmd_ptr #(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_o,
  output logic [DATA_W-1:0] ptr_hi_o
);
  logic [DATA_W-1:0] ptr_q, ptr_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      ptr_hi_q <= '0;
    end else begin
      if (lo_we) ptr_q    <= {wdata[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (hi_we) ptr_hi_q <= wdata;
    end
  end

  assign ptr_o    = ptr_q;
  assign ptr_hi_o = ptr_hi_q;

  assert_ptr_store_R9: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (ptr_q[DATA_W-1:ALIGN_BITS] == $past(wdata[DATA_W-1:ALIGN_BITS])));
  assert_ptr_hi_store_R10: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (ptr_hi_q == $past(wdata)));
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(lo_we || hi_we) |=> ($stable(ptr_q) && $stable(ptr_hi_q)));
endmodule

// File: rtl/dma_chan_bus.sv
module dma_chan_bus
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int DEV_W  = 8,
  parameter int NSEL   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [STAT_W-1:0]          stat,
  input  logic [NSEL-1:0][DEV_W-1:0] sel_mask,
  input  logic [NSEL-1:0][DEV_W-1:0] sel_value,
  input  logic [DATA_W-1:0]          ptr,
  input  logic [DATA_W-1:0]          ptr_hi,
  output logic                       ctl_we,
  output logic [NSEL-1:0]            sel_we,
  output logic                       ptr_we,
  output logic                       ptr_hi_we,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int HALF   = DATA_W / 2;

  logic [WIDX_W-1:0] widx;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q, mapped;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign ctl_we    = bus_we && (widx == WIDX_W'(WIDX_CTRL));
  assign ptr_we    = bus_we && (widx == WIDX_W'(WIDX_PTR));
  assign ptr_hi_we = bus_we && (widx == WIDX_W'(WIDX_PTR_HI));

  for (genvar g = 0; g < NSEL; g++) begin : g_sel_dec
    assign sel_we[g] = bus_we && (widx == WIDX_W'(WIDX_SEL0 + g));
  end

  always_comb begin
    rd_mux = '0;
    mapped = 1'b1;
    case (widx)
      WIDX_W'(WIDX_CTRL):   rd_mux = '0;
      WIDX_W'(WIDX_STAT):   rd_mux = DATA_W'(stat);
      WIDX_W'(WIDX_PTR_HI): rd_mux = ptr_hi;
      WIDX_W'(WIDX_PTR):    rd_mux = ptr;
      default:              mapped = 1'b0;
    endcase
    for (int i = 0; i < NSEL; i++) begin
      if (widx == WIDX_W'(WIDX_SEL0 + i)) begin
        rd_mux = '0;
        rd_mux[HALF +: DEV_W] = sel_mask[i];
        rd_mux[0 +: DEV_W]    = sel_value[i];
        mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_re;
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> rvalid_q);
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> !rvalid_q);
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !mapped) |=> (rdata_q == '0));
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_we, sel_we, ptr_we, ptr_hi_we}));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int DEV_W      = 8,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DEV_W-1:0]  hw_dev_mask,
  input  logic [DEV_W-1:0]  hw_dev_val,
  output logic [DEV_W-1:0]  dev_status,
  output logic              run_o,
  output logic              pause_o,
  output logic              wake_o,
  output logic              dead_o,
  output logic              active_o,
  output logic              irq_cond,
  output logic              branch_cond,
  output logic              wait_cond,
  output logic [DATA_W-1:0] cmd_ptr,
  output logic [DATA_W-1:0] cmd_ptr_hi
);
  localparam int STAT_W = DATA_W / 2;

  logic [STAT_W-1:0]                stat;
  logic                             ctl_we, ptr_we, ptr_hi_we;
  logic [NUM_SEL-1:0]               sel_we, cond;
  logic [NUM_SEL-1:0][DEV_W-1:0]    sel_mask, sel_value;

  dma_chan_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .DEV_W(DEV_W), .NSEL(NUM_SEL)
  ) u_bus (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .stat(stat), .sel_mask(sel_mask), .sel_value(sel_value),
    .ptr(cmd_ptr), .ptr_hi(cmd_ptr_hi),
    .ctl_we(ctl_we), .sel_we(sel_we), .ptr_we(ptr_we), .ptr_hi_we(ptr_hi_we),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  dma_chan_status #(.STAT_W(STAT_W), .DEV_W(DEV_W)) u_status (
    .clk(clk), .rst(rst), .ctl_we(ctl_we),
    .ctl_en(bus_wdata[DATA_W-1:STAT_W]), .ctl_val(bus_wdata[STAT_W-1:0]),
    .hw_mask(hw_dev_mask), .hw_val(hw_dev_val),
    .stat_o(stat), .active_o(active_o)
  );

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    dma_cond_sel #(.DEV_W(DEV_W)) u_sel (
      .clk(clk), .rst(rst), .wr_en(sel_we[g]),
      .wr_mask(bus_wdata[STAT_W +: DEV_W]), .wr_value(bus_wdata[0 +: DEV_W]),
      .dev_status(stat[DEV_W-1:0]),
      .mask_o(sel_mask[g]), .value_o(sel_value[g]), .cond_o(cond[g])
    );
  end

  dma_cmd_ptr #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk(clk), .rst(rst), .lo_we(ptr_we), .hi_we(ptr_hi_we), .wdata(bus_wdata),
    .ptr_o(cmd_ptr), .ptr_hi_o(cmd_ptr_hi)
  );

  assign dev_status  = stat[DEV_W-1:0];
  assign run_o       = stat[BIT_RUN];
  assign pause_o     = stat[BIT_PAUSE];
  assign wake_o      = stat[BIT_WAKE];
  assign dead_o      = stat[BIT_DEAD];
  assign irq_cond    = cond[SEL_IRQ];
  assign branch_cond = cond[SEL_BR];
  assign wait_cond   = cond[SEL_WAIT];

  assert_active_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    (dead_o || pause_o) |=> !active_o);
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we, bus_re;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  hw_dev_mask, hw_dev_val, dev_status;
  logic        run_o, pause_o, wake_o, dead_o, active_o;
  logic        irq_cond, branch_cond, wait_cond;
  logic [31:0] cmd_ptr, cmd_ptr_hi;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .hw_dev_mask(hw_dev_mask), .hw_dev_val(hw_dev_val), .dev_status(dev_status),
    .run_o(run_o), .pause_o(pause_o), .wake_o(wake_o), .dead_o(dead_o),
    .active_o(active_o), .irq_cond(irq_cond), .branch_cond(branch_cond),
    .wait_cond(wait_cond), .cmd_ptr(cmd_ptr), .cmd_ptr_hi(cmd_ptr_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // Driver: issue a read and push the expected word for the monitor.
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // Monitor: compare each returned word with the oldest expectation.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read data: actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    hw_dev_mask = 0; hw_dev_val = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 flags", {27'b0, run_o, pause_o, wake_o, dead_o, active_o}, 32'h0);
    chk("R1 conds", {29'b0, irq_cond, branch_cond, wait_cond}, 32'h0);
    chk("R1 dev", {24'b0, dev_status}, 32'h0);
    rd(8'h04, 32'h0, "R1 status read");
    rd(8'h10, 32'h0, "R1 irq sel read");
    rd(8'h18, 32'h0, "R1 wait sel read");
    rd(8'h0C, 32'h0, "R1 ptr read");
    rd(8'h08, 32'h0, "R1 ptr hi read");

    // R3/R4 run word: enable run,pause,wake,dead; set run only
    wr(8'h00, {16'hD800, 16'h8000});
    chk("R3 run set", {31'b0, run_o}, 32'h1);
    chk("R4 active lags run", {31'b0, active_o}, 32'h0);
    @(negedge clk);
    chk("R4 active after lag", {31'b0, active_o}, 32'h1);
    rd(8'h04, 32'h0000_8400, "R2 status after run");

    // R2 masked device writes
    wr(8'h00, {16'h000F, 16'h00A5});
    wr(8'h00, {16'h00F0, 16'h0030});
    chk("R2 dev masked", {24'b0, dev_status}, 32'h35);
    rd(8'h04, 32'h0000_8435, "R2 status zero-extended");
    wr(8'h00, {16'h0400, 16'h0000});
    chk("R4 active not writable", {31'b0, active_o}, 32'h1);

    // R4 pause then wake
    wr(8'h00, {16'h4000, 16'h4000});
    chk("R3 pause set", {30'b0, pause_o, run_o}, 32'h3);
    chk("R4 active before pause lag", {31'b0, active_o}, 32'h1);
    @(negedge clk);
    chk("R4 active cleared by pause", {31'b0, active_o}, 32'h0);
    wr(8'h00, {16'hD800, 16'h9000});
    chk("R3 wake word", {28'b0, run_o, pause_o, wake_o, dead_o}, 32'b1010);
    @(negedge clk);
    chk("R4 active after wake", {31'b0, active_o}, 32'h1);

    // R4 stop: run cleared, active one cycle later, poll status
    wr(8'h00, {16'h8000, 16'h0000});
    chk("R3 run cleared", {31'b0, run_o}, 32'h0);
    chk("R4 active before stop lag", {31'b0, active_o}, 32'h1);
    @(negedge clk);
    chk("R4 active after stop", {31'b0, active_o}, 32'h0);
    rd(8'h04, 32'h0000_1035, "R4 stop poll status");

    // R5 engine update
    @(negedge clk);
    hw_dev_mask = 8'hC0; hw_dev_val = 8'hFF;
    @(negedge clk);
    hw_dev_mask = 8'h00; hw_dev_val = 8'h00;
    chk("R5 engine update", {24'b0, dev_status}, 32'hF5);
    chk("R5 run-state untouched", {28'b0, run_o, pause_o, wake_o, dead_o}, 32'b0010);

    // R6 collision: sw enables bits 7,0 to zero, engine drives bits 7,1,0 to one
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = {16'h0081, 16'h0000};
    hw_dev_mask = 8'h83; hw_dev_val = 8'h83;
    @(negedge clk);
    bus_we = 1'b0; hw_dev_mask = 8'h00; hw_dev_val = 8'h00;
    chk("R6 software wins", {24'b0, dev_status}, 32'h76);

    // R7/R8 selectors
    wr(8'h10, 32'hAB0F_1E06);
    wr(8'h14, 32'h00F0_0080);
    wr(8'h18, 32'h0000_0000);
    @(negedge clk);
    chk("R8 irq match", {31'b0, irq_cond}, 32'h1);
    chk("R8 branch mismatch", {31'b0, branch_cond}, 32'h0);
    chk("R8 wait open mask", {31'b0, wait_cond}, 32'h1);
    rd(8'h10, 32'h000F_0006, "R7 irq sel readback");
    rd(8'h14, 32'h00F0_0080, "R7 branch sel readback");
    wr(8'h18, 32'h00FF_0000);
    wr(8'h00, {16'h00F0, 16'h0080});
    chk("R8 branch lags status", {31'b0, branch_cond}, 32'h0);
    @(negedge clk);
    chk("R8 branch after status", {31'b0, branch_cond}, 32'h1);
    chk("R8 irq holds", {31'b0, irq_cond}, 32'h1);
    chk("R8 wait full mask", {31'b0, wait_cond}, 32'h0);

    // R9/R10 command pointers
    wr(8'h0C, 32'h1234_567F);
    chk("R9 ptr aligned", cmd_ptr, 32'h1234_5670);
    rd(8'h0C, 32'h1234_5670, "R9 ptr readback");
    wr(8'h08, 32'hDEAD_BEEF);
    chk("R10 ptr hi", cmd_ptr_hi, 32'hDEAD_BEEF);
    rd(8'h08, 32'hDEAD_BEEF, "R10 ptr hi readback");

    // R11 unmapped and control reads
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0, "R11 unmapped read");
    rd(8'h00, 32'h0, "R11 control read");
    rd(8'h04, 32'h0000_1086, "R11 status untouched");
    rd(8'h18, 32'h00FF_0000, "R11 wait sel untouched");

    // R4 dead blocks active
    wr(8'h00, {16'h0800, 16'h0800});
    chk("R3 dead set", {31'b0, dead_o}, 32'h1);
    wr(8'h00, {16'h8000, 16'h8000});
    repeat (2) @(negedge clk);
    chk("R4 dead blocks active", {31'b0, active_o}, 32'h0);
    rd(8'h04, 32'h0000_9886, "R4 status with dead");

    repeat (3) @(negedge clk);
    chk("R11 all reads returned", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule